// File: doc/BRIEF.md
# Card Command Issue Controller

This block is the host-facing command register bank and issue sequencer of an SD/MMC-style card controller. Software loads a command word together with an argument, a timeout, a card type, a block size, a byte count and three clock control values through a simple write port. It reads them back through a combinational read port. Setting the start flag in the command word asks the block to pass a frozen copy of those values to the card-side engine over a request/acknowledge pair.

The start flag clears itself when the engine acknowledges. While the flag is pending, the control registers are locked: a write to any of them is dropped and a lock-error flag is raised. A command may instead be marked clock-update-only. In that case only the three clock values travel to the engine and no completion is ever reported. A command may also be told to hold back while a previous data transfer is still running. Three sticky raw interrupt flags (command done, lock error, illegal boot request) are cleared by writing ones to them.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: A write to the command register (address 0) with bit 31 set makes `start_pending` high after that edge. The bit clears on the edge where `issue_req` and `issue_ack` are both high. `issue_req` is never high without `start_pending`.
- R2: A write to any address 0..8 while `start_pending` is high sets `irq_raw[1]` (lock error) on that edge.
- R3: The locked write of R2 is discarded, so the register reads back its previous value.
- R4: `issue_req` rises one edge after the start flag is seen with the issue condition met. For a normal command, `snap_cmd`, `snap_arg`, `snap_tmo`, `snap_ctype`, `snap_blksz` and `snap_bytcnt` then equal the register contents (addresses 0..5). They and `issue_req` stay stable until acknowledged.
- R5: A command with bit 21 set is clock-only. `issue_clk_only` is high, only `snap_clkdiv`, `snap_clksrc` and `snap_clkena` (addresses 6..8) are loaded, and `irq_raw[0]` is not set for that issue.
- R6: With bit 13 set, no request is made while `data_busy` is high. The request rises on the edge after `data_busy` is first sampled low.
- R7: With bit 13 clear, the request rises on the next edge regardless of `data_busy`.
- R8: After the acknowledge of a normal command, a `resp_done` pulse sets `irq_raw[0]` (command done) on that edge.
- R9: A command write with bit 31, bit 24 and bit 26 all set is rejected. The word is stored with bit 31 clear, no request is made, and `irq_raw[2]` is set.
- R10: Raw interrupt bits are sticky. Writing address 9 clears those bits whose data bit is 1, and a set on the same edge wins. The bits read back at address 9.
- R11: After reset the command register reads 0x2000_0000 (bit 29 set), all other registers and `irq_raw` read zero, and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Write address |
| host_wdata | input | DATA_W | Write data |
| host_raddr | input | ADDR_W | Read address |
| host_rdata | output | DATA_W | Read data (combinational) |
| data_busy | input | 1 | A previous data transfer is still running |
| issue_req | output | 1 | Request to the card-side engine |
| issue_ack | input | 1 | Engine accepts the request |
| issue_clk_only | output | 1 | Current/last issue carries clock values only |
| resp_done | input | 1 | Engine: command sent and response received |
| snap_cmd | output | DATA_W | Frozen command word |
| snap_arg | output | DATA_W | Frozen argument |
| snap_tmo | output | DATA_W | Frozen timeout |
| snap_ctype | output | DATA_W | Frozen card type |
| snap_blksz | output | DATA_W | Frozen block size |
| snap_bytcnt | output | DATA_W | Frozen byte count |
| snap_clkdiv | output | DATA_W | Frozen clock divider |
| snap_clksrc | output | DATA_W | Frozen clock source |
| snap_clkena | output | DATA_W | Frozen clock enable |
| start_pending | output | 1 | Start flag of the command register |
| irq_raw | output | 3 | Raw flags: 0 done, 1 lock error, 2 illegal boot |

## Verification
On every cycle the assertions check several properties. The start flag drops right after a handshake, and a request never exists without it. A locked write and a boot rejection each leave their flags set. The frozen values hold while a request waits. A request for a waiting command never rises while the previous transfer is busy, and completion never comes from a clock-only issue. Other properties need the bench's scenarios: that a locked write really leaves the old register content, that the snapshot matches what software wrote, that a clock-only issue never raises command done, and that sticky flags clear selectively under write-one.

// File: rtl/cmd_issue_pkg.sv
package cmd_issue_pkg;
  // control register addresses; 0..5 travel with a command, 6..8 with a clock update
  localparam int A_CMD    = 0;
  localparam int A_ARG    = 1;
  localparam int A_TMO    = 2;
  localparam int A_CTYPE  = 3;
  localparam int A_BLKSZ  = 4;
  localparam int A_BYTCNT = 5;
  localparam int A_CLKDIV = 6;
  localparam int A_CLKSRC = 7;
  localparam int A_CLKENA = 8;
  localparam int A_IRQ    = 9;
  localparam int NCTRL    = A_CLKENA + 1;

  // command word bit positions
  localparam int B_START   = 31;
  localparam int B_HOLD    = 29;
  localparam int B_BOOTDIS = 26;
  localparam int B_BOOTEN  = 24;
  localparam int B_CLKONLY = 21;
  localparam int B_WAITPRV = 13;

  // raw interrupt bits
  localparam int IRQ_W  = 3;
  localparam int I_DONE = 0;
  localparam int I_LOCK = 1;
  localparam int I_BOOT = 2;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RESP} issue_st_e;

  function automatic logic is_ctrl_addr(input int unsigned a);
    return a <= A_CLKENA;
  endfunction

  function automatic logic is_clk_reg(input int unsigned a);
    return (a >= A_CLKDIV) && (a <= A_CLKENA);
  endfunction

  function automatic logic boot_conflict(input logic [31:0] w);
    return w[B_BOOTEN] & w[B_BOOTDIS];
  endfunction

  function automatic logic issue_gate(input logic [31:0] w, input logic busy);
    return w[B_CLKONLY] | ~w[B_WAITPRV] | ~busy;
  endfunction

  function automatic logic [31:0] reg_reset(input int unsigned a);
    return (a == A_CMD) ? (32'h1 << B_HOLD) : 32'h0;
  endfunction
endpackage

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmd_issue_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              start_clr,
  output logic [DATA_W-1:0] regs_q [NCTRL],
  output logic              lock_evt,
  output logic              boot_rej_evt
);
  logic locked;
  logic ctrl_hit;
  logic wr_ok;

  assign locked       = regs_q[A_CMD][B_START];
  assign ctrl_hit     = wr_en && is_ctrl_addr(int'(wr_addr));
  assign lock_evt     = ctrl_hit && locked;
  assign wr_ok        = ctrl_hit && !locked;
  assign boot_rej_evt = wr_ok && (int'(wr_addr) == A_CMD) &&
                        wr_data[B_START] && boot_conflict(wr_data[31:0]);

  for (genvar g = 0; g < NCTRL; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    logic              hit;
    assign hit = wr_ok && (int'(wr_addr) == g);
    if (g == A_CMD) begin : g_cmd
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          q <= DATA_W'(reg_reset(g));
        end else if (hit) begin
          q <= boot_rej_evt ? (wr_data & ~(DATA_W'(1) << B_START)) : wr_data;
        end else if (start_clr) begin
          q[B_START] <= 1'b0;
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (!rst_n)   q <= DATA_W'(reg_reset(g));
        else if (hit) q <= wr_data;
      end
    end
    assign regs_q[g] = q;
  end
endmodule

// File: rtl/cmd_issue_fsm.sv
module cmd_issue_fsm
  import cmd_issue_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] regs_q [NCTRL],
  input  logic              data_busy,
  input  logic              issue_ack,
  input  logic              resp_done,
  output logic              issue_req,
  output logic              issue_clk_only,
  output logic [DATA_W-1:0] snap_q [NCTRL],
  output logic              launch,
  output logic              start_clr,
  output logic              done_evt
);
  issue_st_e st_q, st_d;
  logic      clk_only_q;
  logic      clk_only_now;
  logic      pend;

  assign pend         = regs_q[A_CMD][B_START];
  assign clk_only_now = regs_q[A_CMD][B_CLKONLY];
  assign launch       = (st_q == ST_IDLE) && pend && issue_gate(regs_q[A_CMD][31:0], data_busy);
  assign start_clr    = (st_q == ST_REQ) && issue_ack;
  assign done_evt     = (st_q == ST_RESP) && resp_done;
  assign issue_req    = (st_q == ST_REQ);
  assign issue_clk_only = clk_only_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (launch)    st_d = ST_REQ;
      ST_REQ:  if (issue_ack) st_d = clk_only_q ? ST_IDLE : ST_RESP;
      ST_RESP: if (resp_done) st_d = ST_IDLE;
      default:                st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      clk_only_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (launch) clk_only_q <= clk_only_now;
    end
  end

  // each snapshot slot loads only when its group (command or clock) is issued
  for (genvar g = 0; g < NCTRL; g++) begin : g_snap
    logic [DATA_W-1:0] s;
    always_ff @(posedge clk) begin
      if (!rst_n) s <= '0;
      else if (launch && (is_clk_reg(g) == clk_only_now)) s <= regs_q[g];
    end
    assign snap_q[g] = s;
  end
endmodule

// File: rtl/cmd_irq_status.sv
module cmd_irq_status
  import cmd_issue_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_W-1:0] set_vec,
  input  logic [IRQ_W-1:0] clr_vec,
  output logic [IRQ_W-1:0] raw_q
);
  for (genvar b = 0; b < IRQ_W; b++) begin : g_bit
    logic f;
    always_ff @(posedge clk) begin
      if (!rst_n)          f <= 1'b0;
      else if (set_vec[b]) f <= 1'b1;
      else if (clr_vec[b]) f <= 1'b0;
    end
    assign raw_q[b] = f;
  end
endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl
  import cmd_issue_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [ADDR_W-1:0] host_raddr,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              data_busy,
  output logic              issue_req,
  input  logic              issue_ack,
  output logic              issue_clk_only,
  input  logic              resp_done,
  output logic [DATA_W-1:0] snap_cmd,
  output logic [DATA_W-1:0] snap_arg,
  output logic [DATA_W-1:0] snap_tmo,
  output logic [DATA_W-1:0] snap_ctype,
  output logic [DATA_W-1:0] snap_blksz,
  output logic [DATA_W-1:0] snap_bytcnt,
  output logic [DATA_W-1:0] snap_clkdiv,
  output logic [DATA_W-1:0] snap_clksrc,
  output logic [DATA_W-1:0] snap_clkena,
  output logic              start_pending,
  output logic [2:0]        irq_raw
);
  logic [DATA_W-1:0] regs_q [NCTRL];
  logic [DATA_W-1:0] snap_q [NCTRL];
  logic              lock_evt, boot_rej_evt, launch, start_clr, done_evt;
  logic [IRQ_W-1:0]  set_vec, clr_vec, raw_q;

  cmd_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(host_wr), .wr_addr(host_addr),
    .wr_data(host_wdata), .start_clr(start_clr), .regs_q(regs_q),
    .lock_evt(lock_evt), .boot_rej_evt(boot_rej_evt)
  );

  cmd_issue_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .regs_q(regs_q), .data_busy(data_busy),
    .issue_ack(issue_ack), .resp_done(resp_done), .issue_req(issue_req),
    .issue_clk_only(issue_clk_only), .snap_q(snap_q), .launch(launch),
    .start_clr(start_clr), .done_evt(done_evt)
  );

  always_comb begin
    set_vec         = '0;
    set_vec[I_DONE] = done_evt;
    set_vec[I_LOCK] = lock_evt;
    set_vec[I_BOOT] = boot_rej_evt;
    clr_vec = (host_wr && int'(host_addr) == A_IRQ) ? host_wdata[IRQ_W-1:0] : '0;
  end

  cmd_irq_status u_irq (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .raw_q(raw_q)
  );

  always_comb begin
    host_rdata = '0;
    for (int i = 0; i < NCTRL; i++)
      if (int'(host_raddr) == i) host_rdata = regs_q[i];
    if (int'(host_raddr) == A_IRQ) host_rdata = DATA_W'(raw_q);
  end

  assign start_pending = regs_q[A_CMD][B_START];
  assign irq_raw       = raw_q;
  assign snap_cmd      = snap_q[A_CMD];
  assign snap_arg      = snap_q[A_ARG];
  assign snap_tmo      = snap_q[A_TMO];
  assign snap_ctype    = snap_q[A_CTYPE];
  assign snap_blksz    = snap_q[A_BLKSZ];
  assign snap_bytcnt   = snap_q[A_BYTCNT];
  assign snap_clkdiv   = snap_q[A_CLKDIV];
  assign snap_clksrc   = snap_q[A_CLKSRC];
  assign snap_clkena   = snap_q[A_CLKENA];
endmodule

// File: rtl/cmd_issue_ctrl_chk.sv
module cmd_issue_ctrl_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue_req,
  input logic              issue_ack,
  input logic              issue_clk_only,
  input logic              start_pending,
  input logic              data_busy,
  input logic [2:0]        irq_raw,
  input logic [DATA_W-1:0] snap_cmd,
  input logic [DATA_W-1:0] snap_clkdiv,
  input logic              lock_evt,
  input logic              boot_rej_evt,
  input logic              done_evt
);
  p_start_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_req && issue_ack |=> !start_pending);
  p_req_needs_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    issue_req |-> start_pending);
  p_lock_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_evt |=> irq_raw[1]);
  p_snap_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    issue_req && !issue_ack |=> issue_req && $stable(snap_cmd) && $stable(snap_clkdiv));
  p_no_done_clk_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |-> !issue_clk_only);
  p_wait_prev_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(issue_req) && !issue_clk_only && snap_cmd[13] |-> !$past(data_busy));
  p_done_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> irq_raw[0]);
  p_boot_reject_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_rej_evt |=> !start_pending && irq_raw[2]);
endmodule

bind cmd_issue_ctrl cmd_issue_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .issue_req(issue_req), .issue_ack(issue_ack),
  .issue_clk_only(issue_clk_only), .start_pending(start_pending),
  .data_busy(data_busy), .irq_raw(irq_raw), .snap_cmd(snap_cmd),
  .snap_clkdiv(snap_clkdiv), .lock_evt(lock_evt), .boot_rej_evt(boot_rej_evt),
  .done_evt(done_evt)
);

// File: tb/cmd_issue_ctrl_test.sv
`timescale 1ns/1ps
module cmd_issue_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic        host_wr = 0;
  logic [3:0]  host_addr = 0, host_raddr = 0;
  logic [31:0] host_wdata = 0, host_rdata;
  logic        data_busy = 0, issue_req, issue_ack = 0, issue_clk_only, resp_done = 0;
  logic [31:0] snap_cmd, snap_arg, snap_tmo, snap_ctype, snap_blksz, snap_bytcnt;
  logic [31:0] snap_clkdiv, snap_clksrc, snap_clkena;
  logic        start_pending;
  logic [2:0]  irq_raw;

  always #2.5 clk = ~clk;

  cmd_issue_ctrl uut (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int ack_lat = 0, resp_lat = 2, wcnt = 0, rcnt = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // behavioural reference model, advanced on each rising edge
  logic [31:0] m_reg [9];
  logic [31:0] m_snap [9];
  int          m_st;
  bit          m_co;
  bit [2:0]    m_irq;

  always @(posedge clk) begin
    logic [31:0] old_cmd;
    bit [2:0] setv, clrv;
    cyc++;
    if (!rst_n) begin
      foreach (m_reg[i]) begin m_reg[i] = 0; m_snap[i] = 0; end
      m_reg[0] = 32'h2000_0000; m_st = 0; m_co = 0; m_irq = 0;
    end else begin
      old_cmd = m_reg[0]; setv = 0; clrv = 0;
      if (m_st == 0) begin
        if (old_cmd[31] && (old_cmd[21] || !old_cmd[13] || !data_busy)) begin
          m_st = 1; m_co = old_cmd[21];
          for (int i = 0; i < 9; i++) if ((i >= 6) == old_cmd[21]) m_snap[i] = m_reg[i];
        end
      end else if (m_st == 1) begin
        if (issue_ack) begin m_reg[0][31] = 0; m_st = m_co ? 0 : 2; end
      end else if (resp_done) begin
        setv[0] = 1; m_st = 0;
      end
      if (host_wr) begin
        if (host_addr == 9) clrv = host_wdata[2:0];
        else if (host_addr <= 8) begin
          if (old_cmd[31]) setv[1] = 1;
          else if (host_addr == 0 && host_wdata[31] && host_wdata[24] && host_wdata[26]) begin
            m_reg[0] = host_wdata & 32'h7FFF_FFFF; setv[2] = 1;
          end else m_reg[host_addr] = host_wdata;
        end
      end
      m_irq = (m_irq & ~clrv) | setv;
    end
    if (cyc > 20000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc);
      finish_run();
    end
  end

  // per-cycle comparison and card-side engine, both on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R4 req", {31'b0, issue_req}, {31'b0, m_st == 1});
      check("R1 start", {31'b0, start_pending}, {31'b0, m_reg[0][31]});
      check("R10 irq", {29'b0, irq_raw}, {29'b0, m_irq});
      check("R5 clk_only", {31'b0, issue_clk_only}, {31'b0, m_co});
      if (m_st == 1 && !m_co) begin
        check("R4 snap_cmd", snap_cmd, m_snap[0]);
        check("R4 snap_bytcnt", snap_bytcnt, m_snap[5]);
      end
      if (m_st == 1 && m_co) check("R5 snap_clkena", snap_clkena, m_snap[8]);
    end
    resp_done = 0;
    if (rcnt > 0) begin rcnt--; if (rcnt == 0) resp_done = 1; end
    if (issue_req) begin
      wcnt++;
      issue_ack = (wcnt > ack_lat);
      if (issue_ack && !issue_clk_only) rcnt = resp_lat;
    end else begin
      wcnt = 0; issue_ack = 0;
    end
  end

  task automatic host_write(input logic [3:0] a, input logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic read_chk(input string tag, input logic [3:0] a, input logic [31:0] exp);
    host_raddr = a; #0.5;
    check(tag, host_rdata, exp);
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!issue_req && n < 200) begin @(negedge clk); n++; end
    check(tag, {31'b0, issue_req}, 32'd1);
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while ((start_pending || m_st != 0) && n < 200) begin @(negedge clk); n++; end
    check(tag, {31'b0, start_pending}, 32'd0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset values
    read_chk("R11 cmd reset", 4'd0, 32'h2000_0000);
    read_chk("R11 arg reset", 4'd1, 32'h0);
    read_chk("R11 irq reset", 4'd9, 32'h0);
    check("R11 req reset", {31'b0, issue_req}, 32'd0);

    // R4/R8/R1: normal command with response
    host_write(4'd1, 32'hA5A5_0001);
    host_write(4'd4, 32'h200);
    host_write(4'd5, 32'h400);
    ack_lat = 2; resp_lat = 3;
    host_write(4'd0, 32'h8000_0051);
    wait_req("R4 request raised");
    check("R4 snap_arg", snap_arg, 32'hA5A5_0001);
    check("R4 snap_blksz", snap_blksz, 32'h200);
    wait_idle("R1 start cleared");
    repeat (5) @(negedge clk);
    check("R8 done flag", {29'b0, irq_raw}, 32'd1);
    read_chk("R1 cmd readback", 4'd0, 32'h0000_0051);
    host_write(4'd9, 32'h1);
    check("R10 w1c clear", {29'b0, irq_raw}, 32'd0);

    // R2/R3: locked write is flagged and discarded
    ack_lat = 8;
    host_write(4'd0, 32'h8000_0042);
    host_write(4'd1, 32'hDEAD_BEEF);
    check("R2 lock flag", {31'b0, irq_raw[1]}, 32'd1);
    read_chk("R3 arg kept", 4'd1, 32'hA5A5_0001);
    wait_idle("R1 start cleared after lock");
    repeat (5) @(negedge clk);
    host_write(4'd9, 32'h2);
    check("R10 selective clear", {29'b0, irq_raw}, 32'd1);
    host_write(4'd9, 32'h7);

    // R5: clock-only issue
    ack_lat = 1;
    host_write(4'd6, 32'h4);
    host_write(4'd8, 32'h1);
    host_write(4'd0, 32'h8020_0000);
    wait_req("R5 clock request");
    check("R5 clk_only flag", {31'b0, issue_clk_only}, 32'd1);
    check("R5 snap_clkdiv", snap_clkdiv, 32'h4);
    check("R5 snap_arg untouched", snap_arg, 32'hA5A5_0001);
    wait_idle("R5 start cleared");
    repeat (10) @(negedge clk);
    check("R5 no done", {31'b0, irq_raw[0]}, 32'd0);

    // R6: wait for previous data
    ack_lat = 0;
    data_busy = 1;
    host_write(4'd0, 32'h8000_2011);
    for (int i = 0; i < 10; i++) begin
      check("R6 held while busy", {31'b0, issue_req}, 32'd0);
      @(negedge clk);
    end
    data_busy = 0;
    @(negedge clk);
    check("R6 issued after busy", {31'b0, issue_req}, 32'd1);
    wait_idle("R6 done");
    repeat (5) @(negedge clk);
    host_write(4'd9, 32'h7);

    // R7: immediate issue despite busy
    data_busy = 1;
    host_write(4'd0, 32'h8000_000D);
    @(negedge clk);
    check("R7 immediate", {31'b0, issue_req}, 32'd1);
    wait_idle("R7 done");
    data_busy = 0;
    repeat (5) @(negedge clk);
    host_write(4'd9, 32'h7);

    // R9: illegal boot combination
    host_write(4'd0, 32'h8500_0000);
    check("R9 start not set", {31'b0, start_pending}, 32'd0);
    check("R9 boot flag", {31'b0, irq_raw[2]}, 32'd1);
    read_chk("R9 stored word", 4'd0, 32'h0500_0000);
    @(negedge clk);
    check("R9 no request", {31'b0, issue_req}, 32'd0);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule